// File: doc/BRIEF.md
# PPS-Triggered Clock Burst Gate

Once per second this block lets through a burst made of whole periods of a source clock. A rising edge on the pulse-per-second input opens the burst, and the next step of a slower advance strobe closes it. The burst length therefore follows the strobe interval. It does not come from a loaded count. A two-stage shift register takes PPS as its serial input and moves only at a step. A step is the first rising edge of the selected source phase after each rising edge of the strobe. The window is open while the first stage holds 1 and the second holds 0. The output is high only while the window is open and the source phase is low, so each burst starts and ends on a full source period.

A mode input picks one of two sources. Mode 0 selects a fast source; its phase is the source itself. Mode 1 selects a slow source; its phase is the inverted slow source, so the output pulses line up with the slow source's high half. All logic runs on one system clock. PPS, the strobe and both sources pass through synchronisers, and their edges become single-cycle enables. A parameter can add an output register that retimes the burst to the system clock. A pulse count reports the number of output pulses in the last completed window, so the burst length can be checked against the strobe timing.

Top module: `pps_burst_gate`

## Requirements
- R1: A synchronous reset (rst high) clears both shift stages, the step-pending state and the mode to fast. In the first cycle after reset is released, burst_out is 0 and pulse_count is 0. A burst cut short by reset does not resume.
- R2: The stages advance only at a step. A step is the first rising edge of the selected phase that follows a strobe rising edge, both seen after synchronisation. At a step, stage 0 takes the synchronised PPS level and stage 1 takes the old stage 0.
- R3: The window is open only while stage 0 is 1 and stage 1 is 0. PPS held high across several strobe steps gives exactly one window, one strobe interval long.
- R4: burst_out is high only while the window is open and the selected phase is low. When RETIME is 1 it is delayed by one register. A window one strobe interval long yields exactly interval/period output pulses when the interval is a whole multiple of the source period.
- R5: With mode 0 the selected phase is fast_src_in, and the stages step on its rising edge.
- R6: With mode 1 the selected phase is the inverse of slow_src_in. The stages step on its falling edge, and the output pulses line up with its high half.
- R7: mode_in is taken only in a cycle where the window is closed and no step occurs. A mode change while a window is open cannot shorten or lengthen that burst. The new mode takes effect for the next burst.
- R8: pulse_count takes the number of output pulses of a window at the step that closes it. It holds that value until the next window closes, and it saturates at all ones.
- R9: With no PPS rising edge, burst_out stays 0 and pulse_count stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pps_in | input | 1 | Pulse-per-second input (asynchronous) |
| strobe_in | input | 1 | Advance strobe; its rising edges arm a step (asynchronous) |
| fast_src_in | input | 1 | Fast source clock, sampled as data |
| slow_src_in | input | 1 | Slow source clock, sampled as data |
| mode_in | input | 1 | Source select: 0 fast, 1 slow |
| burst_out | output | 1 | Gated burst of source pulses |
| pulse_count | output | CW | Number of output pulses in the last completed window |

## Verification
A mode change request and the step that opens a window can fall in the same system cycle. The bench provokes this by moving the mode_in change tick by tick across the moment the window opens. In every run the burst must come out whole in one mode. The reported pulse_count must be either the fast-mode count or the slow-mode count, and it must match the number of pulses the bench counts on burst_out. Over the sweep both outcomes must appear.

// File: rtl/pps_burst_gate.sv
module pps_burst_gate #(
  parameter int CW     = 16,
  parameter int SYNC   = 2,
  parameter bit RETIME = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pps_in,
  input  logic          strobe_in,
  input  logic          fast_src_in,
  input  logic          slow_src_in,
  input  logic          mode_in,
  output logic          burst_out,
  output logic [CW-1:0] pulse_count
);

  logic [SYNC-1:0] pps_sy, stb_sy, fst_sy, slw_sy;
  logic pps_s, stb_s, fst_s, slw_s;
  logic mode_q, mode_nx;
  logic ph, ph_d, ph_rise, ph_fall;
  logic stb_d, stb_rise, pending, shift;
  logic sr0, sr1, win, burst_raw;
  logic [CW-1:0] cnt;

  assign pps_s = pps_sy[SYNC-1];
  assign stb_s = stb_sy[SYNC-1];
  assign fst_s = fst_sy[SYNC-1];
  assign slw_s = slw_sy[SYNC-1];

  assign ph       = mode_q ? ~slw_s : fst_s;
  assign ph_rise  = ph & ~ph_d;
  assign ph_fall  = ~ph & ph_d;
  assign stb_rise = stb_s & ~stb_d;
  assign shift    = ph_rise & pending;
  assign win      = sr0 & ~sr1;
  assign burst_raw = win & ~ph;
  assign mode_nx  = (win | shift) ? mode_q : mode_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      pps_sy      <= '0;
      stb_sy      <= '0;
      fst_sy      <= '0;
      slw_sy      <= '0;
      stb_d       <= 1'b0;
      mode_q      <= 1'b0;
      ph_d        <= 1'b0;
      pending     <= 1'b0;
      sr0         <= 1'b0;
      sr1         <= 1'b0;
      cnt         <= '0;
      pulse_count <= '0;
    end else begin
      pps_sy  <= {pps_sy[SYNC-2:0], pps_in};
      stb_sy  <= {stb_sy[SYNC-2:0], strobe_in};
      fst_sy  <= {fst_sy[SYNC-2:0], fast_src_in};
      slw_sy  <= {slw_sy[SYNC-2:0], slow_src_in};
      stb_d   <= stb_s;
      mode_q  <= mode_nx;
      ph_d    <= mode_nx ? ~slw_s : fst_s;
      pending <= stb_rise | (pending & ~shift);
      if (shift) begin
        sr0 <= pps_s;
        sr1 <= sr0;
        if (pps_s & ~sr0) cnt <= '0;
        if (win) pulse_count <= cnt;
      end else if (win & ph_fall & ~&cnt) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  if (RETIME) begin : g_retime
    logic burst_q;
    always_ff @(posedge clk) begin
      if (rst) burst_q <= 1'b0;
      else     burst_q <= burst_raw;
    end
    assign burst_out = burst_q;
  end else begin : g_direct
    assign burst_out = burst_raw;
  end

endmodule

// File: rtl/pps_burst_gate_chk.sv
module pps_burst_gate_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          burst_out,
  input logic          burst_raw,
  input logic          win,
  input logic          shift,
  input logic          mode_q,
  input logic          sr0,
  input logic          sr1,
  input logic [CW-1:0] pulse_count
);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!burst_out && pulse_count == '0));

  assert_step_only_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable({sr0, sr1}) |-> $past(shift));

  assert_whole_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(burst_raw) |-> (win && $past(win)));

  assert_mode_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (win && $past(win)) |-> $stable(mode_q));

  assert_count_at_close_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(pulse_count) |-> ($past(win) && !win));

endmodule

bind pps_burst_gate pps_burst_gate_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .burst_out(burst_out), .burst_raw(burst_raw),
  .win(win), .shift(shift), .mode_q(mode_q), .sr0(sr0), .sr1(sr1),
  .pulse_count(pulse_count)
);

// File: tb/test_pps_burst_gate.sv
module test_pps_burst_gate;
  localparam int CW = 16;
  localparam int NV = 5;
  // mode, source half period (ticks), strobe interval (ticks), expected pulses
  localparam int VEC [NV][4] = '{
    '{0, 4, 80, 10}, '{0, 3, 96, 16}, '{1, 20, 320, 8},
    '{1, 10, 200, 10}, '{0, 2, 64, 16}};
  localparam int NEVER = 32'h3fff_ffff;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pps = 1'b0, strobe = 1'b0, fsrc = 1'b0, ssrc = 1'b0, mode = 1'b0;
  logic burst_out;
  logic [CW-1:0] pulse_count;

  int checks = 0, fails = 0, t = 0, base = 0, mon = 0, mon_base = 0;
  int ma = 0, mb = 0, flip = NEVER, fh = 4, sh = 20, per = 80;
  int on1 = NEVER, off1 = NEVER, on2 = NEVER, off2 = NEVER, rson = NEVER, rsoff = NEVER;
  int seen_f = 0, seen_s = 0;
  bit rst_req = 1'b1, prev = 1'b0, done = 1'b0;

  always #5 clk = ~clk;

  pps_burst_gate #(.CW(CW), .SYNC(2), .RETIME(1'b1)) i_pps_burst_gate (
    .clk(clk), .rst(rst), .pps_in(pps), .strobe_in(strobe),
    .fast_src_in(fsrc), .slow_src_in(ssrc), .mode_in(mode),
    .burst_out(burst_out), .pulse_count(pulse_count));

  always @(negedge clk) begin
    int rt;
    t = t + 1;
    rt = t - base;
    fsrc   = ((rt / fh) % 2) == 1;
    ssrc   = ((rt / sh) % 2) == 1;
    strobe = (rt % per) < (per / 2);
    pps    = (rt >= on1 && rt < off1) || (rt >= on2 && rt < off2);
    mode   = (rt >= flip) ? mb[0] : ma[0];
    rst    = rst_req || (rt >= rson && rt < rsoff);
    if (burst_out && !prev) mon = mon + 1;
    prev = burst_out;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic defaults();
    ma = 0; mb = 0; flip = NEVER; fh = 4; sh = 20; per = 80;
    on1 = NEVER; off1 = NEVER; on2 = NEVER; off2 = NEVER; rson = NEVER; rsoff = NEVER;
  endtask

  task automatic go();
    @(negedge clk);
    rst_req = 1'b1;
    base = t;
    repeat (4) @(negedge clk);
    rst_req = 1'b0;
    mon_base = mon;
  endtask

  task automatic wait_rt(input int x);
    while ((t - base) < x) @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    defaults();
    go();
    @(negedge clk);
    chk(burst_out == 1'b0, "R1 burst_out after reset", int'(burst_out), 0);
    chk(pulse_count == '0, "R1 pulse_count after reset", int'(pulse_count), 0);

    // R4 R5 R6 R8: table of modes and timings
    for (int i = 0; i < NV; i++) begin
      defaults();
      ma = VEC[i][0]; per = VEC[i][2];
      if (ma == 0) fh = VEC[i][1]; else begin sh = VEC[i][1]; fh = 4; end
      on1 = per + per / 2; off1 = on1 + per;
      go();
      wait_rt(4 * per);
      chk(pulse_count == CW'(VEC[i][3]), ma == 0 ? "R5 R8 fast count" : "R6 R8 slow count",
          int'(pulse_count), VEC[i][3]);
      chk(mon - mon_base == VEC[i][3], "R4 pulses seen on burst_out", mon - mon_base, VEC[i][3]);
    end

    // R3: PPS held high across three steps gives one window
    defaults();
    on1 = 120; off1 = 360;
    go();
    wait_rt(560);
    chk(mon - mon_base == 10, "R3 single window for held PPS", mon - mon_base, 10);
    chk(pulse_count == CW'(10), "R3 count for held PPS", int'(pulse_count), 10);

    // R9: no PPS edge
    defaults();
    go();
    wait_rt(480);
    chk(mon - mon_base == 0, "R9 no pulses without PPS", mon - mon_base, 0);
    chk(pulse_count == '0, "R9 count without PPS", int'(pulse_count), 0);

    // R7: mode change inside a window, next burst in new mode
    defaults();
    per = 320; fh = 4; sh = 20; ma = 0; mb = 1;
    on1 = 480; off1 = 800; flip = 800; on2 = 1440; off2 = 1760;
    go();
    wait_rt(1120);
    chk(pulse_count == CW'(40), "R7 burst kept in old mode", int'(pulse_count), 40);
    wait_rt(2240);
    chk(pulse_count == CW'(8), "R7 next burst in new mode", int'(pulse_count), 8);
    chk(mon - mon_base == 48, "R7 total pulses over two bursts", mon - mon_base, 48);

    // R1: reset in the middle of a burst
    defaults();
    on1 = 120; off1 = 200; rson = 200; rsoff = 206;
    go();
    wait_rt(203);
    chk(burst_out == 1'b0, "R1 burst_out low during reset", int'(burst_out), 0);
    chk(pulse_count == '0, "R1 count cleared by reset", int'(pulse_count), 0);
    mon_base = mon;
    wait_rt(400);
    chk(mon - mon_base == 0, "R1 burst not resumed after reset", mon - mon_base, 0);

    // R7 R2: mode change swept across the window-opening step
    for (int d = -4; d <= 16; d++) begin
      defaults();
      per = 160; fh = 4; sh = 10; ma = 0; mb = 1;
      on1 = 240; off1 = 400; flip = 320 + d;
      go();
      wait_rt(640);
      if (pulse_count == CW'(20)) seen_f++;
      if (pulse_count == CW'(8)) seen_s++;
      chk((pulse_count == CW'(20) || pulse_count == CW'(8)) && (mon - mon_base == int'(pulse_count)),
          "R7 whole burst at mode/step collision", int'(pulse_count), mon - mon_base);
    end
    chk(seen_f > 0 && seen_s > 0, "R2 R7 both outcomes seen in sweep", seen_f * 100 + seen_s, 101);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule